// File: doc/BRIEF.md
# Hashed Page Table Index Generator

This block turns a segment identifier, an effective address and a segment size into the virtual page number, and then into the hash that picks the group of entries to search in a hashed page table. Besides the raw hash it produces two group indices: one for the primary search and one for the secondary search. Both are restricted by a mask that reflects the table size.

Each request comes with a valid strobe. The result appears, registered, on the next clock edge. A new request can be accepted on every cycle. The base page shift must be one of three supported values (12, 16 or 24 by default). For any other shift the block raises an error strobe in place of the valid strobe.

Two segment sizes are handled. Small segments are 256 MB and place the page index in 16 bits. Large segments are 1 TB and place it in 28 bits. The hash folds the segment identifier differently for each size.

Top module: `hpt_index_gen`

## Requirements
- R1: With `in_seg_1t`=0 the VPN is (VSID << 16) | EA[27:12], kept to 64 bits.
- R2: With `in_seg_1t`=1 the VPN is (VSID << 28) | EA[39:12], kept to 64 bits; VSID bits shifted beyond bit 63 are lost.
- R3: With `in_seg_1t`=0 the hash is (VPN >> 16) XOR ((VPN & 0xFFFF) >> (shift − 12)).
- R4: With `in_seg_1t`=1, taking s = VPN >> 28, the hash is s XOR (s << 25) XOR ((VPN & 0xFFFFFFF) >> (shift − 12)).
- R5: The hash output keeps only the low 39 bits of the value from R3 or R4.
- R6: The primary group index equals hash AND `in_mask`.
- R7: The secondary group index equals (NOT hash) AND `in_mask`, so it never shares a set bit with the primary index.
- R8: `in_pshift` values 12, 16 and 24 are accepted. Any other value gives `out_err`=1 and `out_valid`=0 on the result cycle. `out_valid` and `out_err` are never high together.
- R9: A request presented with `in_valid` at clock edge N shows its result at edge N+1. Requests on consecutive cycles each produce a result on consecutive cycles.
- R10: In a cycle without `in_valid`, `out_valid` and `out_err` go low and the data outputs keep their previous values.
- R11: While `rst` is high at a clock edge, `out_valid`, `out_err` and all data outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_vsid | input | 37 | Segment identifier |
| in_ea | input | 64 | Effective address |
| in_seg_1t | input | 1 | Segment size: 0 = 256 MB, 1 = 1 TB |
| in_pshift | input | 6 | Base page shift (log2 of the page size) |
| in_mask | input | 39 | Table group mask |
| out_valid | output | 1 | Result strobe for a request with a supported shift |
| out_err | output | 1 | Result strobe for a request with an unsupported shift |
| out_vpn | output | 64 | Virtual page number |
| out_hash | output | 39 | Truncated hash |
| out_grp_pri | output | 39 | Primary group index |
| out_grp_sec | output | 39 | Secondary group index |

## Verification
The bench keeps the default widths: a 37-bit VSID, a 64-bit VPN and a 39-bit hash. This means that the loss of high VSID bits in 1 TB segments and the truncation of the hash to 39 bits both actually occur. For every segment size and every pattern, the bench sweeps all 64 codes of the 6-bit shift input, with one request per cycle. This covers each supported shift and every unsupported code under back-to-back traffic. The operands include all-zero, all-ones, alternating and pseudo-random values, and the masks vary from pattern to pattern.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int VPN_W        = 64;
    localparam int HASH_W       = 39;
    localparam int PAGE_BASE    = 12;
    localparam int SEGBITS_S    = 28;
    localparam int SEGBITS_L    = 40;
    localparam int SUB_S        = SEGBITS_S - PAGE_BASE;
    localparam int SUB_L        = SEGBITS_L - PAGE_BASE;
    localparam int FOLD_L       = 25;

    typedef enum logic [1:0] {
        PG_SMALL = 2'd0,
        PG_MID   = 2'd1,
        PG_BIG   = 2'd2,
        PG_BAD   = 2'd3
    } pcode_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [HASH_W-1:0] hash;
        logic [HASH_W-1:0] pri;
        logic [HASH_W-1:0] sec;
    } idx_result_t;

    function automatic pcode_e page_code(input int unsigned ps,
                                         input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        if (ps == a)      return PG_SMALL;
        else if (ps == b) return PG_MID;
        else if (ps == c) return PG_BIG;
        return PG_BAD;
    endfunction

endpackage

// File: rtl/hpt_vpn_build.sv
module hpt_vpn_build
    import hpt_pkg::*;
#(
    parameter int VSID_W = 37,
    parameter int EA_W   = 64
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [EA_W-1:0]   ea,
    input  logic              seg_1t,
    output logic [VPN_W-1:0]  vpn
);
    localparam int PAD = VPN_W - VSID_W;

    logic [VPN_W-1:0] vsid_wide;
    logic [VPN_W-1:0] page_s;
    logic [VPN_W-1:0] page_l;

    assign vsid_wide = {{PAD{1'b0}}, vsid};
    assign page_s    = {{(VPN_W-SUB_S){1'b0}}, ea[PAGE_BASE +: SUB_S]};
    assign page_l    = {{(VPN_W-SUB_L){1'b0}}, ea[PAGE_BASE +: SUB_L]};

    always_comb begin
        if (seg_1t) vpn = (vsid_wide << SUB_L) | page_l;
        else        vpn = (vsid_wide << SUB_S) | page_s;
    end
endmodule

// File: rtl/hpt_hash_core.sv
module hpt_hash_core
    import hpt_pkg::*;
#(
    parameter int PS_SMALL = 12,
    parameter int PS_MID   = 16,
    parameter int PS_BIG   = 24
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic              seg_1t,
    input  pcode_e            pcode,
    output logic [HASH_W-1:0] hash
);
    localparam int SH_A   = PS_SMALL - PAGE_BASE;
    localparam int SH_B   = PS_MID   - PAGE_BASE;
    localparam int SH_C   = PS_BIG   - PAGE_BASE;
    localparam int TOP_L  = VPN_W - SUB_L;

    logic [SUB_S-1:0]  pidx_s;
    logic [SUB_L-1:0]  pidx_l;
    logic [HASH_W-1:0] seg_s;
    logic [HASH_W-1:0] seg_l;
    logic [HASH_W-1:0] fold_l;

    always_comb begin
        case (pcode)
            PG_MID:  begin pidx_s = vpn[SUB_S-1:0] >> SH_B; pidx_l = vpn[SUB_L-1:0] >> SH_B; end
            PG_BIG:  begin pidx_s = vpn[SUB_S-1:0] >> SH_C; pidx_l = vpn[SUB_L-1:0] >> SH_C; end
            default: begin pidx_s = vpn[SUB_S-1:0] >> SH_A; pidx_l = vpn[SUB_L-1:0] >> SH_A; end
        endcase
    end

    assign seg_s  = vpn[SUB_S +: HASH_W];
    assign seg_l  = {{(HASH_W-TOP_L){1'b0}}, vpn[VPN_W-1:SUB_L]};
    assign fold_l = seg_l ^ (seg_l << FOLD_L);

    always_comb begin
        if (seg_1t) hash = fold_l ^ {{(HASH_W-SUB_L){1'b0}}, pidx_l};
        else        hash = seg_s  ^ {{(HASH_W-SUB_S){1'b0}}, pidx_s};
    end
endmodule

// File: rtl/hpt_group_sel.sv
module hpt_group_sel
    import hpt_pkg::*;
(
    input  logic [HASH_W-1:0] hash,
    input  logic [HASH_W-1:0] mask,
    output logic [HASH_W-1:0] grp_pri,
    output logic [HASH_W-1:0] grp_sec
);
    assign grp_pri = hash & mask;
    assign grp_sec = ~hash & mask;
endmodule

// File: rtl/hpt_index_gen.sv
module hpt_index_gen
    import hpt_pkg::*;
#(
    parameter int VSID_W   = 37,
    parameter int EA_W     = 64,
    parameter int PS_W     = 6,
    parameter int PS_SMALL = 12,
    parameter int PS_MID   = 16,
    parameter int PS_BIG   = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VSID_W-1:0] in_vsid,
    input  logic [EA_W-1:0]   in_ea,
    input  logic              in_seg_1t,
    input  logic [PS_W-1:0]   in_pshift,
    input  logic [HASH_W-1:0] in_mask,
    output logic              out_valid,
    output logic              out_err,
    output logic [VPN_W-1:0]  out_vpn,
    output logic [HASH_W-1:0] out_hash,
    output logic [HASH_W-1:0] out_grp_pri,
    output logic [HASH_W-1:0] out_grp_sec
);
    pcode_e       pcode;
    logic         shift_ok;
    idx_result_t  nxt;
    idx_result_t  res_q;

    assign pcode    = page_code(int'(in_pshift), PS_SMALL, PS_MID, PS_BIG);
    assign shift_ok = (pcode != PG_BAD);

    hpt_vpn_build #(.VSID_W(VSID_W), .EA_W(EA_W)) vpn_i (
        .vsid   (in_vsid),
        .ea     (in_ea),
        .seg_1t (in_seg_1t),
        .vpn    (nxt.vpn)
    );

    hpt_hash_core #(.PS_SMALL(PS_SMALL), .PS_MID(PS_MID), .PS_BIG(PS_BIG)) hash_i (
        .vpn    (nxt.vpn),
        .seg_1t (in_seg_1t),
        .pcode  (pcode),
        .hash   (nxt.hash)
    );

    hpt_group_sel grp_i (
        .hash    (nxt.hash),
        .mask    (in_mask),
        .grp_pri (nxt.pri),
        .grp_sec (nxt.sec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid & shift_ok;
            out_err   <= in_valid & ~shift_ok;
            if (in_valid) res_q <= nxt;
        end
    end

    assign out_vpn     = res_q.vpn;
    assign out_hash    = res_q.hash;
    assign out_grp_pri = res_q.pri;
    assign out_grp_sec = res_q.sec;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err)); // R8

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((out_valid || out_err) == $past(in_valid))); // R9

    AST_BAD_SHIFT_ONLY: assert property (@(posedge clk) disable iff (rst)
        out_err |-> ($past(in_pshift) != PS_W'(PS_SMALL) &&
                     $past(in_pshift) != PS_W'(PS_MID) &&
                     $past(in_pshift) != PS_W'(PS_BIG))); // R8

    AST_GROUP_SPLIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_grp_pri | out_grp_sec) == $past(in_mask) &&
                       (out_grp_pri & out_grp_sec) == '0)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(out_hash) && $stable(out_vpn))); // R10
endmodule

// File: tb/hpt_index_gen_tb_top.sv
module hpt_index_gen_tb_top;
    localparam int NPAT = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [36:0] in_vsid = '0;
    logic [63:0] in_ea = '0;
    logic        in_seg_1t = 1'b0;
    logic [5:0]  in_pshift = '0;
    logic [38:0] in_mask = '0;
    logic        out_valid, out_err;
    logic [63:0] out_vpn;
    logic [38:0] out_hash, out_grp_pri, out_grp_sec;

    int checks = 0;
    int errors = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    hpt_index_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vsid(in_vsid),
        .in_ea(in_ea), .in_seg_1t(in_seg_1t), .in_pshift(in_pshift),
        .in_mask(in_mask), .out_valid(out_valid), .out_err(out_err),
        .out_vpn(out_vpn), .out_hash(out_hash),
        .out_grp_pri(out_grp_pri), .out_grp_sec(out_grp_sec)
    );

    function automatic logic [63:0] nxt_rng(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    function automatic logic [63:0] exp_vpn(input logic [36:0] v, input logic [63:0] ea, input logic big);
        logic [63:0] w = {27'd0, v};
        if (big) return (w << 28) | ((ea >> 12) & 64'hFFFFFFF);
        return (w << 16) | ((ea >> 12) & 64'hFFFF);
    endfunction

    function automatic logic [38:0] exp_hash(input logic [63:0] vpn, input logic big, input int ps);
        logic [63:0] h;
        logic [63:0] s;
        if (!big) h = (vpn >> 16) ^ ((vpn & 64'hFFFF) >> (ps - 12));
        else begin
            s = vpn >> 28;
            h = s ^ (s << 25) ^ ((vpn & 64'hFFFFFFF) >> (ps - 12));
        end
        return h[38:0];
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] ev;
        logic [38:0] eh;
        logic [63:0] last_vpn;
        logic [38:0] last_hash;
        repeat (3) @(posedge clk);
        #1;
        check64("R11 valid after reset", {63'd0, out_valid}, 64'd0);
        check64("R11 err after reset", {63'd0, out_err}, 64'd0);
        check64("R11 vpn after reset", out_vpn, 64'd0);
        check64("R11 hash after reset", {25'd0, out_hash}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < NPAT; p++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int ps = 0; ps < 64; ps++) begin
                    @(negedge clk);
                    rng = nxt_rng(rng);
                    case (p)
                        0: begin in_vsid = '0; in_ea = '0; in_mask = '1; end
                        1: begin in_vsid = '1; in_ea = '1; in_mask = '1; end
                        2: begin in_vsid = {19{2'b10}}; in_ea = {32{2'b01}}; in_mask = 39'h0FF; end
                        default: begin
                            in_vsid = rng[36:0];
                            in_ea   = nxt_rng(rng ^ 64'h5555);
                            in_mask = rng[63:25] ^ rng[38:0];
                        end
                    endcase
                    in_seg_1t = sg[0];
                    in_pshift = ps[5:0];
                    in_valid  = 1'b1;
                    @(posedge clk);
                    #1;
                    if (ps == 12 || ps == 16 || ps == 24) begin
                        ev = exp_vpn(in_vsid, in_ea, in_seg_1t);
                        eh = exp_hash(ev, in_seg_1t, ps);
                        check64("R9 R8 valid", {62'd0, out_valid, out_err}, 64'd2);
                        check64(sg ? "R2 vpn" : "R1 vpn", out_vpn, ev);
                        check64(sg ? "R4 R5 hash" : "R3 R5 hash", {25'd0, out_hash}, {25'd0, eh});
                        check64("R6 primary", {25'd0, out_grp_pri}, {25'd0, eh & in_mask});
                        check64("R7 secondary", {25'd0, out_grp_sec}, {25'd0, ~eh & in_mask});
                    end else begin
                        check64("R8 bad shift", {62'd0, out_valid, out_err}, 64'd1);
                    end
                end
            end
        end
        @(negedge clk);
        in_pshift = 6'd16;
        in_seg_1t = 1'b1;
        in_vsid   = 37'h1234567;
        in_ea     = 64'h0000_00AB_CDEF_1000;
        @(posedge clk);
        #1;
        last_vpn  = out_vpn;
        last_hash = out_hash;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_vsid  = in_vsid + 37'd99;
            in_ea    = ~in_ea;
            @(posedge clk);
            #1;
            check64("R10 idle strobes", {62'd0, out_valid, out_err}, 64'd0);
            check64("R10 idle vpn", out_vpn, last_vpn);
            check64("R10 idle hash", {25'd0, out_hash}, {25'd0, last_hash});
        end
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check64("R11 vpn cleared", out_vpn, 64'd0);
        check64("R11 primary cleared", {25'd0, out_grp_pri}, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule